// File: doc/BRIEF.md
# Masked level interrupt controller

This block collects 32 interrupt request lines into a single processor interrupt. It has two registers on a small memory-mapped 32-bit port that completes in one cycle: a cause word and a mask word. The processor interrupt is raised whenever a cause bit is set and its mask bit is also set. Software reads the cause word to find which sources are pending. Most cause bits simply follow their (synchronized) source line, so they clear when the source drops. One position, the reset-switch cause, is instead latched when the active-low button is pressed. That bit stays set until software writes a 1 to it. The cause word also carries a live view of the button itself as a status bit. This status bit never raises the interrupt.

A write of any value to a third offset starts a fixed-length platform-reset pulse. To quiesce the controller, software writes zero to the mask word and all ones to the cause word. Every asynchronous input passes through a two-flop synchronizer before any logic uses it. The register port is a plain select/write-enable strobe: it has no back-pressure and no valid/ready handshake, because every access completes in the cycle it is presented.

Top module: `lic_top`

## Requirements
- R1: After reset the mask word reads 0x00000000, cause bit 1 reads 0, `plat_rst_o` is low and `irq_o` is low.
- R2: The mask word at byte offset 0x04 reads back exactly the last 32-bit value written to it. A mask bit of 1 enables that cause position.
- R3: Cause bits other than 1 and 16, read at offset 0x00, equal the matching `src_i` bit two clock edges after the input changes. Writing 1s to these positions at offset 0x00 has no effect on them.
- R4: Cause bit 1 is set when the synchronized `rsw_btn_n` goes from 1 to 0 (button pressed). It stays 1 after the button is released.
- R5: Cause bit 1 is cleared only by a write to offset 0x00 with data bit 1 equal to 1. A write with data bit 1 equal to 0 leaves it set. A new press in the same cycle as the clearing write wins over the clear.
- R6: Cause bit 16 reads the live synchronized `rsw_btn_n` (0 while pressed). It never raises `irq_o`, even when mask bit 16 is set.
- R7: `irq_o` equals the OR over all bits of (cause AND mask), with bit 16 excluded. It is registered and follows its inputs one clock edge later, so it rises three edges after an enabled source input rises.
- R8: Writing 0x00000000 to offset 0x04 and then 0xFFFFFFFF to offset 0x00 leaves the mask at zero, cause bit 1 clear and `irq_o` low.
- R9: Any write to offset 0x24 drives `plat_rst_o` high for exactly 4 consecutive cycles, starting at the edge that takes the write. A write made while the pulse is running restarts the count.
- R10: Reads at offsets other than 0x00 and 0x04 return zero. Writes to them change no register. `bus_rdata` is zero when no read is selected.
- R11: The `src_i` bits at positions 1 and 16 are ignored: they never set cause bits 1 or 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, same cycle as the strobe |
| src_i | input | 32 | Asynchronous level interrupt sources, active high |
| rsw_btn_n | input | 1 | Asynchronous reset button, active low |
| irq_o | output | 1 | Processor interrupt request |
| plat_rst_o | output | 1 | Platform-reset pulse |

## Verification
The hardest case to reach from the ports is the sticky reset-switch cause interacting with its clear and with the mask. To get there, a press must travel through the synchronizer and the edge detector, be released, and then be followed by clearing writes, some of which carry bit 1 and some of which do not. The random phase toggles the button between settled windows, so presses and releases land both before and after partial clearing writes. It also randomizes the mask so that bit 16 is sometimes enabled while the status bit is high. Directed cases then cover the exact irq latency, the quiesce sequence, the length of the reset pulse, and accesses to unmapped offsets.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int unsigned NSRC       = 32;
  localparam int unsigned OFS_CAUSE  = 'h00;
  localparam int unsigned OFS_MASK   = 'h04;
  localparam int unsigned OFS_PRST   = 'h24;
  localparam int unsigned RSW_BIT    = 1;
  localparam int unsigned STATE_BIT  = 16;
  localparam logic [NSRC-1:0] LVL_SEL =
    ~((NSRC'(1) << RSW_BIT) | (NSRC'(1) << STATE_BIT));
  localparam logic [NSRC-1:0] IRQ_SEL = ~(NSRC'(1) << STATE_BIT);
endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= RST_VAL;
      else if (i == 0) stage_q[i] <= d;
      else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lic_cause.sv
module lic_cause #(
  parameter int unsigned NSRC      = 32,
  parameter int unsigned RSW_BIT   = 1,
  parameter int unsigned STATE_BIT = 16,
  parameter logic [NSRC-1:0] LVL_SEL = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl_s,
  input  logic            btn_n_s,
  input  logic            clr_rsw,
  output logic [NSRC-1:0] cause_w,
  output logic            rsw_lat_q,
  output logic            rsw_fall
);
  logic btn_prev_q;

  // Falling edge of the synchronized active-low button marks a press
  assign rsw_fall = btn_prev_q & ~btn_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_prev_q <= 1'b1;
      rsw_lat_q  <= 1'b0;
    end else begin
      btn_prev_q <= btn_n_s;
      if (rsw_fall)     rsw_lat_q <= 1'b1;
      else if (clr_rsw) rsw_lat_q <= 1'b0;
    end
  end

  always_comb begin
    cause_w            = lvl_s & LVL_SEL;
    cause_w[RSW_BIT]   = rsw_lat_q;
    cause_w[STATE_BIT] = btn_n_s;
  end
endmodule

// File: rtl/lic_pulse.sv
module lic_pulse #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int unsigned CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (trig)           cnt_q <= CW'(LEN);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign pulse = (cnt_q != '0);
endmodule

// File: rtl/lic_top.sv
module lic_top #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PULSE_LEN   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [lic_pkg::NSRC-1:0] bus_wdata,
  output logic [lic_pkg::NSRC-1:0] bus_rdata,
  input  logic [lic_pkg::NSRC-1:0] src_i,
  input  logic                     rsw_btn_n,
  output logic                     irq_o,
  output logic                     plat_rst_o
);
  import lic_pkg::*;

  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_PRST  = ADDR_W'(OFS_PRST);

  logic [NSRC-1:0] lvl_s;
  logic            btn_n_s;
  logic [NSRC-1:0] cause_w;
  logic [NSRC-1:0] mask_q;
  logic            rsw_lat;
  logic            rsw_fall;
  logic            irq_q;
  logic            wr_cause, wr_mask, wr_prst;

  assign wr_cause = bus_sel & bus_we & (bus_addr == A_CAUSE);
  assign wr_mask  = bus_sel & bus_we & (bus_addr == A_MASK);
  assign wr_prst  = bus_sel & bus_we & (bus_addr == A_PRST);

  lic_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_src (
    .clk(clk), .rst_n(rst_n), .d(src_i), .q(lvl_s)
  );

  lic_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_btn (
    .clk(clk), .rst_n(rst_n), .d(rsw_btn_n), .q(btn_n_s)
  );

  lic_cause #(
    .NSRC(NSRC), .RSW_BIT(RSW_BIT), .STATE_BIT(STATE_BIT), .LVL_SEL(LVL_SEL)
  ) u_cause (
    .clk(clk), .rst_n(rst_n), .lvl_s(lvl_s), .btn_n_s(btn_n_s),
    .clr_rsw(wr_cause & bus_wdata[RSW_BIT]),
    .cause_w(cause_w), .rsw_lat_q(rsw_lat), .rsw_fall(rsw_fall)
  );

  lic_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig(wr_prst), .pulse(plat_rst_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(cause_w & mask_q & IRQ_SEL);
  end
  assign irq_o = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (bus_addr == A_CAUSE)     bus_rdata = cause_w;
      else if (bus_addr == A_MASK) bus_rdata = mask_q;
    end
  end
endmodule

// File: rtl/lic_chk.sv
module lic_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_o,
  input logic              plat_rst_o,
  input logic [31:0]       mask_q,
  input logic [31:0]       cause_w,
  input logic              rsw_lat,
  input logic              rsw_fall
);
  logic wr, rd, hit_c, hit_m, hit_p, pend;
  assign wr    = bus_sel & bus_we;
  assign rd    = bus_sel & ~bus_we;
  assign hit_c = (bus_addr == ADDR_W'('h00));
  assign hit_m = (bus_addr == ADDR_W'('h04));
  assign hit_p = (bus_addr == ADDR_W'('h24));
  assign pend  = |(cause_w & mask_q & 32'hFFFE_FFFF);

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_m) |=> (mask_q == $past(bus_wdata))); // R2
  AST_RSW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsw_lat && !(wr && hit_c && bus_wdata[1])) |=> rsw_lat); // R4
  AST_RSW_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_c && bus_wdata[1] && !rsw_fall) |=> !rsw_lat); // R5
  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(pend))); // R7
  AST_PULSE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_p) |=> plat_rst_o); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit_c && !hit_m) |-> (bus_rdata == 32'h0)); // R10
endmodule

bind lic_top lic_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .plat_rst_o(plat_rst_o), .mask_q(mask_q),
  .cause_w(cause_w), .rsw_lat(rsw_lat), .rsw_fall(rsw_fall)
);

// File: tb/tb_lic_top.sv
module tb_lic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_i = '0;
  logic        rsw_btn_n = 1'b1;
  logic        irq_o, plat_rst_o;

  int total = 0, bad = 0;
  bit finished = 0;

  logic        m_lat = 0;
  logic [31:0] m_mask = '0;

  always #2 clk = ~clk;

  lic_top dut (.*);

  function automatic logic [31:0] exp_cause(logic [31:0] s, logic btn, logic lat);
    logic [31:0] c;
    c = s & ~32'h0001_0002;
    c[1] = lat;
    c[16] = btn;
    return c;
  endfunction

  function automatic logic exp_irq(logic [31:0] c, logic [31:0] m);
    return |(c & m & 32'hFFFE_FFFF);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int highs;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 plat_rst", {31'b0, plat_rst_o}, 0);
    rd(8'h04, d); chk("R1 mask", d, 0);
    rd(8'h00, d); chk("R1 cause", d, exp_cause(0, 1, 0));

    // R2 mask readback
    wr(8'h04, 32'hA5C3_0F18); rd(8'h04, d); chk("R2 mask rw", d, 32'hA5C3_0F18);
    wr(8'h04, 32'h0); m_mask = 0;

    // R7 latency: enabled source rises, irq on third edge
    wr(8'h04, 32'h20); m_mask = 32'h20;
    @(negedge clk); src_i = 32'h20;
    idle(2); chk("R7 irq early", {31'b0, irq_o}, 0);
    idle(1); chk("R7 irq on time", {31'b0, irq_o}, 1);
    // R3 level clears on deassert, W1C no effect while high
    wr(8'h00, 32'h20); rd(8'h00, d); chk("R3 w1c ignored", d & 32'h20, 32'h20);
    @(negedge clk); src_i = 0; idle(2);
    rd(8'h00, d); chk("R3 follows drop", d & 32'h20, 0);
    // R11 ignored source bits
    @(negedge clk); src_i = 32'h0001_0002; idle(4);
    rd(8'h00, d); chk("R11 bits 1,16", d, exp_cause(0, 1, 0));
    src_i = 0;

    // R4 press latches, survives release
    wr(8'h04, 32'h2); m_mask = 32'h2;
    @(negedge clk); rsw_btn_n = 0; idle(4);
    rd(8'h00, d); chk("R4 latched", d, exp_cause(0, 0, 1));
    chk("R7 irq rsw", {31'b0, irq_o}, 1);
    @(negedge clk); rsw_btn_n = 1; idle(4);
    rd(8'h00, d); chk("R4 after release", d, exp_cause(0, 1, 1));
    // R5 clear only with bit 1
    wr(8'h00, 32'hFFFF_FFFD); rd(8'h00, d); chk("R5 no clear", d[1], 1);
    wr(8'h00, 32'h2); rd(8'h00, d); chk("R5 clear", d[1], 0);
    idle(1); chk("R5 irq drop", {31'b0, irq_o}, 0);

    // R6 status bit never interrupts
    wr(8'h04, 32'h0001_0000); idle(3);
    rd(8'h00, d); chk("R6 status high", d[16], 1);
    chk("R6 no irq", {31'b0, irq_o}, 0);
    @(negedge clk); rsw_btn_n = 0; idle(3);
    rd(8'h00, d); chk("R6 status pressed", d[16], 0);
    @(negedge clk); rsw_btn_n = 1; idle(3);
    m_lat = 1;

    // R8 quiesce
    wr(8'h04, 32'hFFFF_FFFF);
    @(negedge clk); src_i = 32'h00F0_0F00; idle(4);
    chk("R8 pre irq", {31'b0, irq_o}, 1);
    wr(8'h04, 32'h0); wr(8'h00, 32'hFFFF_FFFF); idle(2);
    chk("R8 irq", {31'b0, irq_o}, 0);
    rd(8'h04, d); chk("R8 mask", d, 0);
    rd(8'h00, d); chk("R8 lat", d[1], 0);
    m_lat = 0; m_mask = 0;

    // R9 pulse length
    wr(8'h24, 32'h0); highs = 0;
    for (int i = 0; i < 8; i++) begin
      if (plat_rst_o) highs++;
      @(negedge clk);
    end
    chk("R9 pulse cycles", highs, 4);
    // R10 unmapped
    wr(8'h04, 32'h1234_5678); wr(8'h08, 32'hFFFF_FFFF); wr(8'h40, 32'h0);
    rd(8'h04, d); chk("R10 write ignored", d, 32'h1234_5678);
    rd(8'h08, d); chk("R10 read 08", d, 0);
    rd(8'h24, d); chk("R10 read 24", d, 0);
    #1 chk("R10 idle rdata", bus_rdata, 0);
    wr(8'h04, 32'h0);

    // Random phase: R3 R4 R5 R6 R7
    begin
      logic btn_m = 1;
      for (int it = 0; it < 60; it++) begin
        logic [31:0] s, c;
        logic nb;
        s  = $urandom;
        nb = ($urandom % 3) != 0;
        @(negedge clk);
        src_i = s; rsw_btn_n = nb;
        if (btn_m && !nb) m_lat = 1;
        btn_m = nb;
        if ($urandom % 2) begin
          m_mask = $urandom; wr(8'h04, m_mask);
        end
        idle(4);
        if ($urandom % 3 == 0) begin
          logic [31:0] w;
          w = $urandom;
          wr(8'h00, w);
          if (w[1]) m_lat = 0;
        end
        idle(1);
        c = exp_cause(s, nb, m_lat);
        rd(8'h00, d); chk("R3/R4/R5/R6 cause", d, c);
        rd(8'h04, d); chk("R2 mask", d, m_mask);
        chk("R7 irq", {31'b0, irq_o}, {31'b0, exp_irq(c, m_mask)});
      end
    end
    finish_run();
  end
endmodule